// File: doc/BRIEF.md
# Dual-Rate Cascaded Integrator-Comb Decimator

This block lowers the sample rate of a 6-bit two's complement stream produced by a fourth-order sigma-delta modulator. It uses no multipliers. A chain of five running accumulators works at the input rate. A rate counter marks every R-th accepted sample. A chain of five first-difference stages then works at the decimated rate and delivers a full-precision 26-bit result.

One select input chooses the ratio at run time. Narrow mode divides by 16 and wide mode divides by 8, which brings oversampling ratios of 64 and 32 down to four times the Nyquist rate. Every register is sized for the larger ratio, so both modes share the same datapath. All arithmetic wraps modulo 2^26. The accumulators may overflow between outputs, and the differences recover the correct value.

When the select changes, the rate counter and the difference-stage memories restart. The first result in the new mode therefore covers a complete period of the new ratio. Gain scaling, droop correction and later filter stages are left to the blocks that follow.

Top module: `cic_dual_decim`

## Requirements
- R1: While the asynchronous active-low reset is held, and on the first cycle after its release, `dec_vld_o` is 0 and `dec_o` is 0.
- R2: On each cycle with `smp_vld_i` high, accumulator 0 adds the sign-extended sample. Each accumulator k (k = 1..4) adds the value that accumulator k-1 held before that edge. All additions wrap modulo 2^26.
- R3: With `wide_mode_i` = 0, one result is produced per 16 accepted samples. With `wide_mode_i` = 1, one result is produced per 8 accepted samples.
- R4: At each decimation tick, the last accumulator value is passed through five cascaded first differences, each with a delay of one decimated sample and each wrapping modulo 2^26. `dec_o` changes only when `dec_vld_o` is high.
- R5: If the R-th sample of a period is accepted in cycle T, then `dec_vld_o` is high for exactly one cycle, cycle T+2, and `dec_o` holds the result in that cycle.
- R6: When `wide_mode_i` differs from the mode currently in use, the rate counter and all difference delays are cleared and any result still pending is cancelled. A sample accepted in that cycle counts as the first sample of the new period.
- R7: A constant input of -32 in narrow mode settles to the most negative 26-bit value (-2^25), even though the accumulators overflow on the way.
- R8: A cycle with `smp_vld_i` low changes neither the accumulators nor the counter, whatever value `smp_i` carries. While no samples arrive, no result is produced and `dec_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | 6 | Modulator sample, two's complement |
| smp_vld_i | input | 1 | Sample strobe |
| wide_mode_i | input | 1 | Ratio select: 0 divides by 16, 1 divides by 8 |
| dec_o | output | 26 | Decimated full-precision result |
| dec_vld_o | output | 1 | One-cycle strobe marking a new result |

## Verification
A mode change can coincide with either end of a period. It can arrive in the same cycle as the R-th sample, which would otherwise raise the tick. It can also arrive in the cycle after that sample, when the difference chain would otherwise update. The bench provokes both cases. It runs its reference model until the tick is one sample away or has just been raised, and then flips the select. The change must win in both cases: no result is expected, the period restarts with that cycle's sample as its first, and every later result must match the model in both value and timing.

// File: rtl/cic_pkg.sv
package cic_pkg;

  typedef enum logic {
    MODE_NARROW = 1'b0,
    MODE_WIDE   = 1'b1
  } rate_mode_e;

  // last counter value of a period for the selected mode
  function automatic int unsigned period_last(input rate_mode_e m,
                                              input int unsigned r_narrow,
                                              input int unsigned r_wide);
    return (m == MODE_WIDE) ? (r_wide - 1) : (r_narrow - 1);
  endfunction

endpackage

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
  parameter int IN_W  = 6,
  parameter int ORDER = 5,
  parameter int ACC_W = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [IN_W-1:0]  smp_i,
  output logic [ACC_W-1:0] last_o
);

  logic [ORDER-1:0][ACC_W-1:0] acc_q;
  logic [ORDER-1:0][ACC_W-1:0] acc_n;
  logic [ACC_W-1:0]            smp_ext;

  assign smp_ext = {{(ACC_W-IN_W){smp_i[IN_W-1]}}, smp_i};

  // ripple adders, each stage fed by the previous stage's register
  always_comb begin
    acc_n = acc_q;
    if (en_i) begin
      acc_n[0] = acc_q[0] + smp_ext;
      for (int k = 1; k < ORDER; k++) begin
        acc_n[k] = acc_q[k] + acc_q[k-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_n;
    end
  end

  assign last_o = acc_q[ORDER-1];

endmodule

// File: rtl/cic_rate_ctrl.sv
module cic_rate_ctrl
  import cic_pkg::*;
#(
  parameter int RATIO_NARROW = 16,
  parameter int RATIO_WIDE   = 8,
  localparam int CNT_W = $clog2(RATIO_NARROW)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_vld_i,
  input  logic wide_mode_i,
  output logic tick_o,
  output logic restart_o
);

  rate_mode_e       mode_q, mode_n, mode_req;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             tick_q, tick_n;
  logic [CNT_W-1:0] cnt_last;

  assign mode_req  = rate_mode_e'(wide_mode_i);
  assign restart_o = (mode_req != mode_q);
  assign cnt_last  = CNT_W'(period_last(mode_q, RATIO_NARROW, RATIO_WIDE));

  always_comb begin
    mode_n = mode_q;
    cnt_n  = cnt_q;
    tick_n = 1'b0;
    if (restart_o) begin
      mode_n = mode_req;
      cnt_n  = smp_vld_i ? CNT_W'(1) : '0;
    end else if (smp_vld_i) begin
      if (cnt_q == cnt_last) begin
        cnt_n  = '0;
        tick_n = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_NARROW;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      mode_q <= mode_n;
      cnt_q  <= cnt_n;
      tick_q <= tick_n;
    end
  end

  assign tick_o = tick_q;

endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
  parameter int ORDER = 5,
  parameter int ACC_W = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [ACC_W-1:0] din_i,
  output logic [ACC_W-1:0] dout_o,
  output logic             dout_vld_o
);

  logic [ORDER-1:0][ACC_W-1:0] dly_q, dly_n;
  logic [ORDER-1:0][ACC_W-1:0] diff;
  logic [ACC_W-1:0]            out_q, out_n;
  logic                        vld_q, vld_n;

  // cascade of first differences, delay of one decimated sample each
  always_comb begin
    diff[0] = din_i - dly_q[0];
    for (int k = 1; k < ORDER; k++) begin
      diff[k] = diff[k-1] - dly_q[k];
    end
  end

  always_comb begin
    dly_n = dly_q;
    out_n = out_q;
    vld_n = 1'b0;
    if (clr_i) begin
      dly_n = '0;
    end else if (en_i) begin
      dly_n[0] = din_i;
      for (int k = 1; k < ORDER; k++) begin
        dly_n[k] = diff[k-1];
      end
      out_n = diff[ORDER-1];
      vld_n = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      dly_q <= dly_n;
      out_q <= out_n;
      vld_q <= vld_n;
    end
  end

  assign dout_o     = out_q;
  assign dout_vld_o = vld_q;

endmodule

// File: rtl/cic_dual_decim.sv
module cic_dual_decim #(
  parameter int IN_W         = 6,
  parameter int ORDER        = 5,
  parameter int RATIO_NARROW = 16,
  parameter int RATIO_WIDE   = 8,
  localparam int ACC_W = IN_W + ORDER * $clog2(RATIO_NARROW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  smp_i,
  input  logic             smp_vld_i,
  input  logic             wide_mode_i,
  output logic [ACC_W-1:0] dec_o,
  output logic             dec_vld_o
);

  logic [ACC_W-1:0] integ_last;
  logic             tick;
  logic             restart;

  cic_integ_chain #(
    .IN_W  (IN_W),
    .ORDER (ORDER),
    .ACC_W (ACC_W)
  ) u_integ (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (smp_vld_i),
    .smp_i  (smp_i),
    .last_o (integ_last)
  );

  cic_rate_ctrl #(
    .RATIO_NARROW (RATIO_NARROW),
    .RATIO_WIDE   (RATIO_WIDE)
  ) u_rate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .smp_vld_i   (smp_vld_i),
    .wide_mode_i (wide_mode_i),
    .tick_o      (tick),
    .restart_o   (restart)
  );

  cic_comb_chain #(
    .ORDER (ORDER),
    .ACC_W (ACC_W)
  ) u_comb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (tick),
    .clr_i      (restart),
    .din_i      (integ_last),
    .dout_o     (dec_o),
    .dout_vld_o (dec_vld_o)
  );

endmodule

// File: rtl/cic_dual_decim_chk.sv
module cic_dual_decim_chk #(
  parameter int ACC_W = 26
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             smp_vld_i,
  input logic             wide_mode_i,
  input logic [ACC_W-1:0] dec_o,
  input logic             dec_vld_o
);

  // R5: strobe lasts a single cycle
  assert_strobe_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_vld_o |=> !dec_vld_o);

  // R5: a result is preceded two cycles earlier by an accepted sample
  assert_strobe_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_vld_o |-> $past(smp_vld_i, 2));

  // R4: result only moves together with its strobe
  assert_out_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_o != $past(dec_o)) |-> dec_vld_o);

  // R6: a mode change cancels the result that would follow it
  assert_mode_cancel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_mode_i != $past(wide_mode_i)) |=> !dec_vld_o);

endmodule

bind cic_dual_decim cic_dual_decim_chk #(.ACC_W(ACC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_vld_i   (smp_vld_i),
  .wide_mode_i (wide_mode_i),
  .dec_o       (dec_o),
  .dec_vld_o   (dec_vld_o)
);

// File: tb/sim_cic_dual_decim.sv
`timescale 1ns/1ps
module sim_cic_dual_decim;

  localparam int W = 26;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [5:0]   smp = '0;
  logic         vld = 1'b0;
  logic         mode = 1'b0;
  logic [W-1:0] dec;
  logic         dec_vld;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cic_dual_decim u0 (
    .clk_i(clk), .rst_ni(rst_n), .smp_i(smp), .smp_vld_i(vld),
    .wide_mode_i(mode), .dec_o(dec), .dec_vld_o(dec_vld)
  );

  typedef struct { logic [W-1:0] v; int c; } exp_t;
  exp_t q[$];

  // reference model state
  logic [W-1:0] mi [5];
  logic [W-1:0] md [5];
  logic [W-1:0] snap;
  int           mcnt = 0;
  logic         mmode = 1'b0;
  logic         pend = 1'b0;
  logic [15:0]  lfsr = 16'hACE1;
  logic [W-1:0] last_out = '0;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ratio(input logic m);
    return m ? 8 : 16;
  endfunction

  // driver with model: push expected results into the scoreboard
  task automatic drive(input logic [5:0] x, input logic v, input logic m);
    logic chg;
    logic [W-1:0] c, o;
    @(negedge clk);
    smp = x; vld = v; mode = m;
    chg = (m != mmode);
    if (chg) begin
      pend = 1'b0;
      mcnt = v ? 1 : 0;
      for (int k = 0; k < 5; k++) md[k] = '0;
      mmode = m;
    end else if (pend) begin
      c = snap;
      for (int k = 0; k < 5; k++) begin
        o = c - md[k];
        md[k] = c;
        c = o;
      end
      q.push_back('{v: c, c: cyc + 1});
      pend = 1'b0;
    end
    if (v) begin
      for (int k = 4; k >= 1; k--) mi[k] = mi[k] + mi[k-1];
      mi[0] = mi[0] + {{(W-6){x[5]}}, x};
    end
    if (!chg && v) begin
      mcnt++;
      if (mcnt == ratio(mmode)) begin
        mcnt = 0;
        pend = 1'b1;
        snap = mi[4];
      end
    end
  endtask

  task automatic rnd(input int n, input logic m);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[5:0], lfsr[9] | lfsr[7], m);
    end
  endtask

  // monitor: compare value and arrival cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (dec_vld) begin
        if (q.size() == 0) begin
          chk(1'b0, "R3 unexpected result", longint'($signed(dec)), 0);
        end else begin
          chk(dec == q[0].v, "R4 result value", longint'($signed(dec)), longint'($signed(q[0].v)));
          chk(cyc == q[0].c, "R5 result cycle", cyc, q[0].c);
          last_out = dec;
          void'(q.pop_front());
        end
      end else if (q.size() > 0 && q[0].c < cyc) begin
        chk(1'b0, "R5 missing result", cyc, q[0].c);
        void'(q.pop_front());
      end
    end
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    for (int k = 0; k < 5; k++) begin mi[k] = '0; md[k] = '0; end
    repeat (3) @(negedge clk);
    chk(dec_vld == 1'b0, "R1 strobe in reset", dec_vld, 0);
    chk(dec == '0, "R1 result in reset", dec, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(dec_vld == 1'b0 && dec == '0, "R1 after release", dec, 0);

    // R2 R3 R4: narrow mode, varied input with gaps
    rnd(200, 1'b0);
    // R3: wide mode (mode change R6)
    rnd(200, 1'b1);
    // R6: change in the cycle after the tick
    while (!pend) rnd(1, 1'b1);
    rnd(60, 1'b0);
    // R6: change on the R-th sample itself
    while (mcnt != ratio(mmode) - 1) drive(6'h15, 1'b1, 1'b0);
    drive(6'h15, 1'b1, 1'b1);
    rnd(60, 1'b1);
    while (!pend) drive(6'h09, 1'b1, 1'b1);
    drive(6'h09, 1'b1, 1'b0);
    rnd(80, 1'b0);

    // R8: idle with garbage on the data input
    repeat (4) drive(6'h00, 1'b0, 1'b0);
    held = dec;
    for (int i = 0; i < 40; i++) drive(6'(i * 7), 1'b0, 1'b0);
    chk(dec == held, "R8 result held while idle", dec, held);
    chk(dec_vld == 1'b0, "R8 no strobe while idle", dec_vld, 0);
    rnd(100, 1'b0);

    // R7: full-scale negative input in narrow mode
    for (int i = 0; i < 16 * 12; i++) drive(6'h20, 1'b1, 1'b0);
    repeat (4) drive(6'h00, 1'b0, 1'b0);
    chk(last_out == {1'b1, {(W-1){1'b0}}}, "R7 full-scale settles",
        longint'($signed(last_out)), -(64'sd1 <<< 25));

    repeat (4) drive(6'h00, 1'b0, 1'b0);
    done = 1'b1;
    chk(q.size() == 0, "R3 all results delivered", q.size(), 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule